// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reset requests into a single system reset. The four requests are power-on, a filtered external reset pin, a brown-out detector and a watchdog timeout. While any request is active, the I/O reset output is driven from combinational logic, so it asserts even when no clock is running. The core reset follows it. Once every request has gone quiet, the core reset is held for a programmable number of clock cycles so that supplies and the oscillator can settle.

The length of the hold comes from two static configuration fields: a 2-bit start-up-time code and a 4-bit clock-class code. The external pin is active low. It passes through a synchronizer and a spike filter, and a configuration bit can remove it as a reset source. A 4-bit cause register can be read at any time and records which sources have triggered a reset. Software clears its flags by writing zeros. The brown-out trip-level field is passed straight through to the analog detector.

Top module: `rst_sequencer`

## Requirements
- R1: `io_rst` is high whenever `por_n` is low, `bod_req` is high, `wdt_req` is high or the pin request has been accepted. It follows these inputs combinationally and needs no clock edge.
- R2: `core_rst` asserts at the same moment as `io_rst`. It stays high after all sources are inactive and falls on exactly the (N+1)th rising edge of `clk` after the last source went inactive, where N is the selected timeout.
- R3: Timeout N is 65536 when `cfg_cksel[3]` is 1 or when `cfg_cksel` equals 4'b0111 (a reserved code). Otherwise N is chosen by `cfg_sut`: 2'b00 gives 0, 2'b01 gives 16, 2'b10 gives 1024 and 2'b11 gives 4096.
- R4: If any source asserts again before the count completes, the count restarts from zero. The (N+1)-edge window is then measured from the new release.
- R5: `pin_n` goes through a two-flop synchronizer and must then be seen low on 4 consecutive edges. A pin held low is accepted on the 6th rising edge after it falls. A low pulse covering only 3 rising edges never causes a reset.
- R6: When `cfg_pin_off` is 1, `pin_n` has no effect on `io_rst`, `core_rst` or status bit 1.
- R7: The `status` bits are: bit 0 power-on, bit 1 external pin, bit 2 brown-out, bit 3 watchdog. While `por_n` is low, `status` reads 4'b0001 with no clock needed.
- R8: A flag sets at a clock edge where its source is active. A write (`st_wr`=1) clears every bit whose `st_wdata` bit is 0 and leaves bits written with 1 unchanged. A set on the same edge wins over the clear.
- R9: `bod_level_o` always equals `cfg_bod_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on request, active low |
| pin_n | input | 1 | External reset pin, active low, asynchronous |
| bod_req | input | 1 | Brown-out request, active high |
| wdt_req | input | 1 | Watchdog timeout request, active high |
| cfg_sut | input | 2 | Start-up-time code |
| cfg_cksel | input | 4 | Clock-class code |
| cfg_pin_off | input | 1 | 1 removes the external pin as a reset source |
| cfg_bod_level | input | 3 | Brown-out trip-level selection |
| st_wr | input | 1 | Cause register write strobe |
| st_wdata | input | 4 | Write data; a 0 bit clears the flag |
| io_rst | output | 1 | Asynchronous I/O reset, active high |
| core_rst | output | 1 | Stretched core reset, active high |
| status | output | 4 | Reset cause flags |
| bod_level_o | output | 3 | Trip level to the brown-out detector |

## Verification
A counter that has lost its place shows up as `core_rst` falling on the wrong edge after release. Because of this, each timeout code is measured edge by edge from the release, including a restart partway through a count. A filter counter that is off by one accepts a 3-edge glitch or delays a real press by an edge, and `io_rst` shows this within six cycles of the pin falling. A wrong set or clear in the cause register is visible on `status` one edge after the event or write that caused it.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    SUT_NONE  = 2'b00,
    SUT_SHORT = 2'b01,
    SUT_MID   = 2'b10,
    SUT_LONG  = 2'b11
  } sut_e;

  localparam int CAUSE_W = 4;

  typedef struct packed {
    logic wdt;
    logic bod;
    logic pin;
    logic por;
  } cause_t;

  localparam cause_t CAUSE_POR_ONLY = '{wdt: 1'b0, bod: 1'b0, pin: 1'b0, por: 1'b1};

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int SYNC_N   = 2,
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic hit_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

  logic [SYNC_N-1:0] sync_q, sync_d;
  logic [CW-1:0]     run_q, run_d;
  logic              low_seen;

  assign low_seen = ~sync_q[SYNC_N-1];

  always_comb begin
    sync_d = {sync_q[SYNC_N-2:0], pin_n};
    if (!low_seen)        run_d = '0;
    else if (run_q == FULL) run_d = run_q;
    else                  run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '1;
      run_q  <= '0;
    end else begin
      sync_q <= sync_d;
      run_q  <= run_d;
    end
  end

  assign hit_o = (run_q == FULL);
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch
  import rst_seq_pkg::*;
#(
  parameter int T_SHORT = 16,
  parameter int T_MID   = 1024,
  parameter int T_LONG  = 4096,
  parameter int T_MAX   = 65536
) (
  input  logic       clk,
  input  logic       src_n,
  input  logic [1:0] sut,
  input  logic [3:0] cksel,
  output logic       core_rst_o
);
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] lim, cnt_q, cnt_d;
  logic             core_q, core_d, cnt_en, done;

  always_comb begin
    if (cksel[3] || cksel == 4'b0111) begin
      lim = CNT_W'(T_MAX);
    end else begin
      case (sut)
        SUT_NONE:  lim = '0;
        SUT_SHORT: lim = CNT_W'(T_SHORT);
        SUT_MID:   lim = CNT_W'(T_MID);
        default:   lim = CNT_W'(T_LONG);
      endcase
    end
  end

  always_comb begin
    done   = (cnt_q == lim);
    cnt_en = core_q && !done;
    cnt_d  = cnt_en ? cnt_q + 1'b1 : cnt_q;
    core_d = core_q && !done;
  end

  always_ff @(posedge clk or negedge src_n) begin
    if (!src_n) begin
      cnt_q  <= '0;
      core_q <= 1'b1;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      core_q <= core_d;
    end
  end

  assign core_rst_o = core_q;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_seq_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic               wr_i,
  input  logic [CAUSE_W-1:0] wdata_i,
  output logic [CAUSE_W-1:0] flags_o
);
  cause_t flags_q, flags_d;
  logic   upd_en;

  always_comb begin
    upd_en  = wr_i || (|set_i);
    flags_d = (wr_i ? (flags_q & cause_t'(wdata_i)) : flags_q) | cause_t'(set_i);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     flags_q <= CAUSE_POR_ONLY;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int T_SHORT  = 16,
  parameter int T_MID    = 1024,
  parameter int T_LONG   = 4096,
  parameter int T_MAX    = 65536
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         pin_n,
  input  logic         bod_req,
  input  logic         wdt_req,
  input  logic [1:0]   cfg_sut,
  input  logic [3:0]   cfg_cksel,
  input  logic         cfg_pin_off,
  input  logic [2:0]   cfg_bod_level,
  input  logic         st_wr,
  input  logic [3:0]   st_wdata,
  output logic         io_rst,
  output logic         core_rst,
  output logic [3:0]   status,
  output logic [2:0]   bod_level_o
);
  logic   pin_hit, pin_ok, src_any, src_n;
  cause_t set_v;

  rst_pin_filter #(.SYNC_N(2), .FILT_LEN(FILT_LEN)) u_filt (
    .clk    (clk),
    .arst_n (por_n),
    .pin_n  (pin_n),
    .hit_o  (pin_hit)
  );

  assign pin_ok  = pin_hit && !cfg_pin_off;
  assign src_any = !por_n || bod_req || wdt_req || pin_ok;
  assign src_n   = !src_any;
  assign io_rst  = src_any;

  rst_stretch #(
    .T_SHORT (T_SHORT),
    .T_MID   (T_MID),
    .T_LONG  (T_LONG),
    .T_MAX   (T_MAX)
  ) u_str (
    .clk        (clk),
    .src_n      (src_n),
    .sut        (cfg_sut),
    .cksel      (cfg_cksel),
    .core_rst_o (core_rst)
  );

  always_comb begin
    set_v.wdt = wdt_req;
    set_v.bod = bod_req;
    set_v.pin = pin_ok;
    set_v.por = 1'b0;
  end

  rst_cause_reg u_cause (
    .clk     (clk),
    .arst_n  (por_n),
    .set_i   (set_v),
    .wr_i    (st_wr),
    .wdata_i (st_wdata),
    .flags_o (status)
  );

  assign bod_level_o = cfg_bod_level;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk (
  input logic       clk,
  input logic       por_n,
  input logic       bod_req,
  input logic       wdt_req,
  input logic       cfg_pin_off,
  input logic       io_rst,
  input logic       core_rst,
  input logic [3:0] status
);
  // R1
  io_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bod_req || wdt_req) |-> io_rst);

  // R2
  core_cover_chk: assert property (@(posedge clk) disable iff (!por_n)
    io_rst |-> core_rst);

  // R2
  quiet_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst) |-> !io_rst);

  // R6
  pin_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_pin_off && !bod_req && !wdt_req) |-> !io_rst);

  // R8
  wdt_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    wdt_req |=> status[3]);
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .bod_req     (bod_req),
  .wdt_req     (wdt_req),
  .cfg_pin_off (cfg_pin_off),
  .io_rst      (io_rst),
  .core_rst    (core_rst),
  .status      (status)
);

// File: tb/rst_sequencer_test.sv
`timescale 1ns/1ps
module rst_sequencer_test;
  logic       clk = 1'b0;
  logic       por_n, pin_n, bod_req, wdt_req, cfg_pin_off, st_wr;
  logic [1:0] cfg_sut;
  logic [3:0] cfg_cksel, st_wdata;
  logic [2:0] cfg_bod_level;
  logic       io_rst, core_rst;
  logic [3:0] status;
  logic [2:0] bod_level_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rst_sequencer uut (
    .clk(clk), .por_n(por_n), .pin_n(pin_n), .bod_req(bod_req), .wdt_req(wdt_req),
    .cfg_sut(cfg_sut), .cfg_cksel(cfg_cksel), .cfg_pin_off(cfg_pin_off),
    .cfg_bod_level(cfg_bod_level), .st_wr(st_wr), .st_wdata(st_wdata),
    .io_rst(io_rst), .core_rst(core_rst), .status(status), .bod_level_o(bod_level_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write_status(input logic [3:0] d);
    @(negedge clk); st_wr = 1'b1; st_wdata = d;
    @(negedge clk); st_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk); por_n = 1'b0; cfg_bod_level = 3'd5; #1;
    check(io_rst == 1'b1, "R1", "io_rst under power-on", io_rst, 1);
    check(core_rst == 1'b1, "R2", "core_rst under power-on", core_rst, 1);
    check(status == 4'b0001, "R7", "status under power-on", status, 1);
    check(bod_level_o == 3'd5, "R9", "level passthrough", bod_level_o, 5);
    @(negedge clk); por_n = 1'b1;
    tick();
    check(core_rst == 1'b0, "R2", "release with zero timeout", core_rst, 0);
  endtask

  task automatic t_async_assert();
    @(posedge clk); #2; bod_req = 1'b1; #1;
    check(io_rst == 1'b1, "R1", "io_rst mid-cycle", io_rst, 1);
    check(core_rst == 1'b1, "R2", "core_rst mid-cycle", core_rst, 1);
    @(negedge clk); bod_req = 1'b0;
    tick();
  endtask

  task automatic t_timeout(input logic [1:0] sut, input logic [3:0] ck, input int n_exp);
    int n = 0;
    @(negedge clk); cfg_sut = sut; cfg_cksel = ck; bod_req = 1'b1;
    @(negedge clk); @(negedge clk); bod_req = 1'b0;
    do begin
      tick(); n++;
      if (core_rst && io_rst) begin
        check(1'b0, "R2", "io_rst after release", 1, 0);
      end
    end while (core_rst && n < 70000);
    // R3 table and R2 edge count
    check(n == n_exp + 1, "R3", "edges to release", n, n_exp + 1);
  endtask

  task automatic t_restart();
    int n = 0;
    @(negedge clk); cfg_sut = 2'b01; cfg_cksel = 4'h0; bod_req = 1'b1;
    @(negedge clk); bod_req = 1'b0;
    repeat (10) tick();
    check(core_rst == 1'b1, "R4", "held mid-count", core_rst, 1);
    @(negedge clk); wdt_req = 1'b1;
    @(negedge clk); wdt_req = 1'b0;
    do begin tick(); n++; end while (core_rst && n < 100);
    check(n == 17, "R4", "edges after re-release", n, 17);
  endtask

  task automatic t_pin_filter();
    int seen = 0;
    cfg_sut = 2'b00; cfg_cksel = 4'h0;
    write_status(4'b0000);
    @(negedge clk); pin_n = 1'b0;
    repeat (3) tick();
    @(negedge clk); pin_n = 1'b1;
    repeat (8) begin tick(); if (io_rst) seen++; end
    check(seen == 0, "R5", "3-edge glitch ignored", seen, 0);
    @(negedge clk); pin_n = 1'b0;
    repeat (5) tick();
    check(io_rst == 1'b0, "R5", "not yet after 5 edges", io_rst, 0);
    tick();
    check(io_rst == 1'b1, "R5", "accepted on 6th edge", io_rst, 1);
    tick();
    check(status[1] == 1'b1, "R8", "pin flag set", status[1], 1);
    @(negedge clk); pin_n = 1'b1;
    repeat (4) tick();
    check(core_rst == 1'b0, "R2", "released after pin", core_rst, 0);
  endtask

  task automatic t_pin_disabled();
    int seen = 0;
    write_status(4'b0000);
    @(negedge clk); cfg_pin_off = 1'b1; pin_n = 1'b0;
    repeat (10) begin tick(); if (io_rst || core_rst) seen++; end
    check(seen == 0, "R6", "pin ignored when disabled", seen, 0);
    check(status == 4'b0000, "R6", "pin flag untouched", status, 0);
    @(negedge clk); pin_n = 1'b1;
    repeat (4) tick();
    @(negedge clk); cfg_pin_off = 1'b0;
  endtask

  task automatic t_status();
    write_status(4'b0000); #1;
    check(status == 4'b0000, "R8", "write zeros clears", status, 0);
    @(negedge clk); wdt_req = 1'b1;
    @(negedge clk); wdt_req = 1'b0; bod_req = 1'b1;
    @(negedge clk); bod_req = 1'b0; #1;
    check(status == 4'b1100, "R8", "wdt and bod flags", status, 12);
    write_status(4'b1111); #1;
    check(status == 4'b1100, "R8", "ones leave flags", status, 12);
    write_status(4'b0111); #1;
    check(status == 4'b0100, "R8", "clear watchdog only", status, 4);
    @(negedge clk); st_wr = 1'b1; st_wdata = 4'b0000; bod_req = 1'b1;
    @(negedge clk); st_wr = 1'b0; bod_req = 1'b0; #1;
    check(status == 4'b0100, "R8", "set wins over clear", status, 4);
    @(negedge clk); por_n = 1'b0; #1;
    check(status == 4'b0001, "R7", "power-on clears others", status, 1);
    @(negedge clk); por_n = 1'b1;
    repeat (2) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0; pin_n = 1'b1; bod_req = 1'b0; wdt_req = 1'b0;
    cfg_sut = 2'b00; cfg_cksel = 4'h0; cfg_pin_off = 1'b0; cfg_bod_level = 3'd0;
    st_wr = 1'b0; st_wdata = 4'h0;
    repeat (3) @(posedge clk);
    t_reset_state();
    t_async_assert();
    t_timeout(2'b00, 4'h2, 0);
    t_timeout(2'b01, 4'h2, 16);
    t_timeout(2'b10, 4'h0, 1024);
    t_timeout(2'b11, 4'h4, 4096);
    t_timeout(2'b00, 4'h9, 65536);
    t_timeout(2'b01, 4'h7, 65536);
    t_restart();
    t_pin_filter();
    t_pin_disabled();
    t_status();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule